// File: doc/BRIEF.md
# Retriggerable Digital One-Shot Timer

This block is a clocked, fully synchronous pulse stretcher that stands in for an RC-timed retriggerable monostable. It has two trigger inputs of opposite sense: one fires on a high-to-low change, the other on a low-to-high change. Each input also acts as an enable for the other. Once a trigger is accepted, output `q_o` goes high for `PULSE_LEN` clock cycles and `qn_o` carries its complement. The RC network is replaced by a down-counter.

A valid trigger that arrives while the pulse is running reloads the counter, so the pulse always ends `PULSE_LEN` cycles after the last accepted trigger. Each accepted trigger is followed by a short blackout (`RETRIG_GAP` cycles) in which further edges are ignored. This models the time the timing node needs to reload. An active-low clear kills the output at once and holds the block idle. Releasing clear never starts a pulse. After release, a recovery window of `CLR_RECOVER` cycles must pass before triggers are accepted again. Both trigger inputs and the clear pass through two-flop synchronisers. The clear path asserts asynchronously and releases synchronously.

Top module: `retrig_oneshot`

## Requirements
- R1: During and after reset, with no trigger edge applied, `q_o` is 0 and `qn_o` is 1.
- R2: A 1-to-0 change on `fall_trig_i` while `rise_trig_i` is 1 and clear is released starts a pulse. If the change is applied just after a rising clock edge, `q_o` is 1 after the third rising edge that follows it, whatever `PULSE_LEN` is.
- R3: A 0-to-1 change on `rise_trig_i` while `fall_trig_i` is 0 and clear is released starts a pulse, with the same latency as R2.
- R4: A falling `fall_trig_i` while `rise_trig_i` is 0 is ignored, and a rising `rise_trig_i` while `fall_trig_i` is 1 is ignored.
- R5: With no further trigger, `q_o` stays high for exactly `PULSE_LEN` clock cycles.
- R6: A valid trigger accepted while `q_o` is high restarts the count, so `q_o` falls `PULSE_LEN` cycles after the last accepted trigger.
- R7: For `RETRIG_GAP` cycles after an accepted trigger, further trigger edges are ignored.
- R8: While `clr_n_i` is 0, `q_o` is 0 and `qn_o` is 1 immediately, without waiting for a clock edge, even in the middle of a pulse.
- R9: Trigger edges that occur while `clr_n_i` is 0 are ignored.
- R10: The 0-to-1 release of `clr_n_i` never starts a pulse.
- R11: After clear is released, two synchroniser cycles and then `CLR_RECOVER` further cycles pass in which triggers are ignored. With the bench values (`CLR_RECOVER`=2), a trigger applied one cycle after release is lost, and one applied two cycles after release gives a pulse.
- R12: `qn_o` is always the inverse of `q_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fall_trig_i | input | 1 | Trigger on 1-to-0 change; enables the rising trigger when low |
| rise_trig_i | input | 1 | Trigger on 0-to-1 change; enables the falling trigger when high |
| clr_n_i | input | 1 | Active-low clear: kills the pulse and blocks triggers |
| q_o | output | 1 | Pulse output, high while timing |
| qn_o | output | 1 | Complement of `q_o` |

## Verification
Directed sequences start pulses from each trigger input in turn. They then repeat the same edges with the other input in its inhibiting level, which shows that the enable gating is applied and not just edge detection. Retriggers are placed just outside and just inside the blackout window, so the sequences separate a count restart from a swallowed edge. Clear is applied mid-pulse, with triggers both during the clear and one or two cycles after release, which locates the exact end of the recovery window. A long random run with sporadic clears is then compared each cycle against a cycle-timing model built from the stated latencies.

// File: rtl/os_pkg.sv
package os_pkg;

    // Synchronised input levels seen by the trigger qualifier.
    typedef struct packed {
        logic a;   // falling-edge trigger input, synchronised
        logic b;   // rising-edge trigger input, synchronised
        logic ok;  // clear released and synchronised
    } os_lvl_t;

    // Bits needed to hold values 0..n, never less than one.
    function automatic int cnt_bits(input int n);
        return (n < 1) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/os_sync.sv
module os_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        logic [WIDTH-1:0] stage_d;
        if (g == 0) begin : g_first
            assign stage_d = d_i;
        end else begin : g_next
            assign stage_d = stage_q[g-1];
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[g] <= '0;
            else        stage_q[g] <= stage_d;
        end
    end

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/os_clr_sync.sv
module os_clr_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_n_i,
    output logic ok_o
);
    typedef struct packed {
        logic meta;
        logic ok;
    } clr_st_t;

    clr_st_t st_d, st_q;
    logic    arst_n;

    assign arst_n = rst_n & clr_n_i;

    always_comb begin
        st_d.meta = 1'b1;
        st_d.ok   = st_q.meta;
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) st_q <= '0;
        else         st_q <= st_d;
    end

    assign ok_o = st_q.ok;
endmodule

// File: rtl/os_qualify.sv
module os_qualify
    import os_pkg::*;
#(
    parameter int RETRIG_GAP  = 2,
    parameter int CLR_RECOVER = 2
) (
    input  logic    clk,
    input  logic    rst_n,
    input  os_lvl_t lvl_i,
    output logic    acc_o
);
    localparam int RW = cnt_bits(CLR_RECOVER);
    localparam int GW = cnt_bits(RETRIG_GAP);

    typedef struct packed {
        logic          a_prev;
        logic          b_prev;
        logic [RW-1:0] rec;
        logic [GW-1:0] gap;
    } q_st_t;

    q_st_t st_d, st_q;
    logic  fall_seen, rise_seen, open_win;

    always_comb begin
        st_d      = st_q;
        fall_seen = st_q.a_prev & ~lvl_i.a & lvl_i.b;
        rise_seen = ~st_q.b_prev & lvl_i.b & ~lvl_i.a;
        open_win  = lvl_i.ok && (st_q.rec == '0) && (st_q.gap == '0);
        acc_o     = open_win && (fall_seen || rise_seen);

        st_d.a_prev = lvl_i.a;
        st_d.b_prev = lvl_i.b;

        if (!lvl_i.ok)             st_d.rec = RW'(CLR_RECOVER);
        else if (st_q.rec != '0)   st_d.rec = st_q.rec - 1'b1;

        if (acc_o)                 st_d.gap = GW'(RETRIG_GAP);
        else if (st_q.gap != '0)   st_d.gap = st_q.gap - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.a_prev <= 1'b0;
            st_q.b_prev <= 1'b0;
            st_q.rec    <= RW'(CLR_RECOVER);
            st_q.gap    <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/os_pulse.sv
module os_pulse
    import os_pkg::*;
#(
    parameter int PULSE_LEN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ok_i,
    input  logic acc_i,
    output logic on_o
);
    localparam int CW = cnt_bits(PULSE_LEN - 1);

    typedef struct packed {
        logic          on;
        logic [CW-1:0] cnt;
    } p_st_t;

    p_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!ok_i) begin
            st_d.on  = 1'b0;
            st_d.cnt = '0;
        end else if (acc_i) begin
            st_d.on  = 1'b1;
            st_d.cnt = CW'(PULSE_LEN - 1);
        end else if (st_q.on) begin
            if (st_q.cnt != '0) st_d.cnt = st_q.cnt - 1'b1;
            else                st_d.on  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign on_o = st_q.on;
endmodule

// File: rtl/retrig_oneshot.sv
module retrig_oneshot
    import os_pkg::*;
#(
    parameter int PULSE_LEN   = 16,
    parameter int RETRIG_GAP  = 2,
    parameter int CLR_RECOVER = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fall_trig_i,
    input  logic rise_trig_i,
    input  logic clr_n_i,
    output logic q_o,
    output logic qn_o
);
    logic [1:0] trig_s;
    logic       clr_ok;
    logic       trig_acc;
    logic       pulse_on;
    os_lvl_t    lvl;

    os_sync #(.WIDTH(2), .STAGES(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({fall_trig_i, rise_trig_i}),
        .q_o   (trig_s)
    );

    os_clr_sync u_clr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_n_i (clr_n_i),
        .ok_o    (clr_ok)
    );

    assign lvl.a  = trig_s[1];
    assign lvl.b  = trig_s[0];
    assign lvl.ok = clr_ok;

    os_qualify #(.RETRIG_GAP(RETRIG_GAP), .CLR_RECOVER(CLR_RECOVER)) u_qual (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl_i (lvl),
        .acc_o (trig_acc)
    );

    os_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
        .clk   (clk),
        .rst_n (rst_n),
        .ok_i  (clr_ok),
        .acc_i (trig_acc),
        .on_o  (pulse_on)
    );

    assign q_o  = pulse_on & clr_ok;
    assign qn_o = ~q_o;
endmodule

// File: rtl/os_chk.sv
module os_chk #(
    parameter int PULSE_LEN   = 16,
    parameter int RETRIG_GAP  = 2,
    parameter int CLR_RECOVER = 2
) (
    input logic clk,
    input logic rst_n,
    input logic clr_n_i,
    input logic q_o,
    input logic qn_o,
    input logic trig_acc
);
    localparam int MAXC    = ((PULSE_LEN > RETRIG_GAP) ? PULSE_LEN : RETRIG_GAP) + 1;
    localparam int SW      = $clog2(MAXC + 1);
    localparam int REL_MAX = CLR_RECOVER + 3;
    localparam int LW      = $clog2(REL_MAX + 1);

    logic [SW-1:0] since_acc;
    logic [LW-1:0] rel_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      since_acc <= SW'(MAXC);
        else if (trig_acc)               since_acc <= SW'(1);
        else if (int'(since_acc) < MAXC) since_acc <= since_acc + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        rel_cnt <= '0;
        else if (!clr_n_i)                 rel_cnt <= '0;
        else if (int'(rel_cnt) < REL_MAX)  rel_cnt <= rel_cnt + 1'b1;
    end

    assert_complement_R12: assert property (@(posedge clk) disable iff (!rst_n)
        qn_o == !q_o);

    assert_clear_forces_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n_i |-> !q_o);

    assert_clear_blocks_trig_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n_i |-> !trig_acc);

    assert_release_no_trig_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clr_n_i) |=> !trig_acc);

    assert_recovery_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n_i && int'(rel_cnt) <= CLR_RECOVER + 2) |-> !q_o);

    assert_gap_respected_R7: assert property (@(posedge clk) disable iff (!rst_n)
        trig_acc |-> int'(since_acc) > RETRIG_GAP);

    assert_pulse_ends_R5: assert property (@(posedge clk) disable iff (!rst_n)
        int'(since_acc) > PULSE_LEN |-> !q_o);

    assert_trig_raises_R6: assert property (@(posedge clk) disable iff (!rst_n)
        trig_acc |=> (q_o || !clr_n_i));
endmodule

bind retrig_oneshot os_chk #(
    .PULSE_LEN   (PULSE_LEN),
    .RETRIG_GAP  (RETRIG_GAP),
    .CLR_RECOVER (CLR_RECOVER)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_n_i  (clr_n_i),
    .q_o      (q_o),
    .qn_o     (qn_o),
    .trig_acc (trig_acc)
);

// File: tb/sim_retrig_oneshot.sv
module sim_retrig_oneshot;
    localparam int W   = 6;
    localparam int GAP = 2;
    localparam int REC = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic a = 1'b1;
    logic b = 1'b1;
    logic clr_n = 1'b1;
    logic q, qn;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    retrig_oneshot #(.PULSE_LEN(W), .RETRIG_GAP(GAP), .CLR_RECOVER(REC)) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .fall_trig_i (a),
        .rise_trig_i (b),
        .clr_n_i     (clr_n),
        .q_o         (q),
        .qn_o        (qn)
    );

    // Timing model derived from the requirements: inputs seen two edges late,
    // clear gating immediate, recovery and blackout windows in cycles.
    bit ah1, ah2, ah3, bh1, bh2, bh3, ch1, ch2;
    bit m_on;
    int m_cnt, m_rec, m_gap;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            {ah1, ah2, ah3, bh1, bh2, bh3, ch1, ch2} = '0;
            m_on = 0; m_cnt = 0; m_rec = REC; m_gap = 0;
        end else begin
            bit ok, fall_e, rise_e, take;
            ok     = clr_n && ch1 && ch2;
            fall_e = ah3 && !ah2 && bh2;
            rise_e = !bh3 && bh2 && !ah2;
            take   = ok && m_rec == 0 && m_gap == 0 && (fall_e || rise_e);
            if (!ok) begin
                m_on = 0; m_cnt = 0;
            end else if (take) begin
                m_on = 1; m_cnt = W - 1;
            end else if (m_on) begin
                if (m_cnt != 0) m_cnt--; else m_on = 0;
            end
            if (!ok) m_rec = REC; else if (m_rec != 0) m_rec--;
            if (take) m_gap = GAP; else if (m_gap != 0) m_gap--;
            ah3 = ah2; ah2 = ah1; ah1 = a;
            bh3 = bh2; bh2 = bh1; bh1 = b;
            ch2 = ch1; ch1 = clr_n;
        end
    end

    function automatic bit model_q(bit on, bit c);
        return on && c;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic go(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic hold_low(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            go(1);
            check(req, q, 0);
        end
    endtask

    initial begin
        void'($urandom(32'h5eed1));
        // R1: reset state
        go(3);
        check("R1 q in reset", q, 0);
        check("R1 qn in reset", qn, 1);
        rst_n = 1'b1;
        hold_low(8, "R1 idle after reset");
        check("R1 qn idle", qn, 1);

        // R2 and R5: falling trigger, latency and width
        a = 1'b0;
        go(2); check("R2 not yet high", q, 0);
        go(1); check("R2 high after latency", q, 1);
        for (int i = 0; i < W - 1; i++) begin
            go(1); check("R5 held high", q, 1);
        end
        go(1); check("R5 low after width", q, 0);
        check("R12 qn after pulse", qn, 1);
        a = 1'b1; go(4);

        // R4: falling edge with rise input low is inhibited
        b = 1'b0; go(2);
        a = 1'b0;
        hold_low(8, "R4 fall inhibited");
        // R3: rising trigger with fall input low
        b = 1'b1;
        go(2); check("R3 not yet high", q, 0);
        go(1); check("R3 high after latency", q, 1);
        check("R12 qn during pulse", qn, 0);
        go(W); check("R5 low after width (rise)", q, 0);

        // R4: rising edge with fall input high is inhibited
        a = 1'b1; go(3);
        b = 1'b0; go(3);
        b = 1'b1;
        hold_low(8, "R4 rise inhibited");

        // R6: retrigger restarts the count
        a = 1'b0; go(3);
        check("R6 first pulse high", q, 1);
        a = 1'b1; go(1);
        a = 1'b0;
        go(5); check("R6 extended past first end", q, 1);
        go(3); check("R6 high to last trigger + width", q, 1);
        go(1); check("R6 low after restarted width", q, 0);
        a = 1'b1; go(4);

        // R7: edge inside the blackout is dropped
        a = 1'b0; go(1);
        a = 1'b1; go(1);
        a = 1'b0;
        go(6); check("R7 pulse still high", q, 1);
        go(1); check("R7 blackout edge ignored", q, 0);
        a = 1'b1; go(4);

        // R8, R9, R10: clear mid pulse, triggers during clear, release
        a = 1'b0; go(4);
        check("R8 pulse running", q, 1);
        clr_n = 1'b0; #1;
        check("R8 q forced low at once", q, 0);
        check("R8 qn forced high at once", qn, 1);
        a = 1'b1; go(1);
        a = 1'b0; go(1);
        check("R9 fall during clear", q, 0);
        b = 1'b0; go(1);
        b = 1'b1;
        hold_low(4, "R9 rise during clear");
        clr_n = 1'b1;
        hold_low(12, "R10 release starts nothing");

        // R11: trigger one cycle after release is lost
        a = 1'b1; b = 1'b1; go(3);
        clr_n = 1'b0; go(3);
        clr_n = 1'b1; go(1);
        a = 1'b0;
        hold_low(12, "R11 trigger inside recovery");
        // R11: trigger two cycles after release is taken
        a = 1'b1; go(3);
        clr_n = 1'b0; go(3);
        clr_n = 1'b1; go(2);
        a = 1'b0;
        go(2); check("R11 not yet high", q, 0);
        go(1); check("R11 trigger after recovery", q, 1);
        go(W + 2);
        a = 1'b1; go(4);

        // Random phase against the timing model (R2 R3 R5 R6 R7 R9 R11 R12)
        for (int i = 0; i < 4000; i++) begin
            int hold;
            go(1);
            check("R6 random q vs model", q, model_q(m_on, clr_n));
            check("R12 random complement", qn, !q);
            if ($urandom_range(99) < 30) a = ~a;
            if ($urandom_range(99) < 30) b = ~b;
            if (clr_n && $urandom_range(99) < 3) begin
                clr_n = 1'b0;
                hold = $urandom_range(4, 1);
                for (int k = 0; k < hold; k++) begin
                    #1;
                    check("R8 random clear", q, 0);
                    go(1);
                    if ($urandom_range(99) < 40) a = ~a;
                end
                clr_n = 1'b1;
            end
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual 1 expected 0 (run hung)");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule